// File: doc/BRIEF.md
# Cascadable Bidirectional Segment Shift Chain

This block is the serial loading stage of a two-phase segment display driver. It holds two bits for every segment, one per backplane phase, and takes them in one bit per rising edge of a serial shift clock. A static direction strap chooses which side of the die is the input side. It picks the active data pin and the active clock pin, and the end of the register where the bits enter. The clock pin on the other side then forwards the shift clock to the next device in a chain.

The bit at the far end of the register is re-registered on the falling edge of the shift clock and drives two identical serial outputs, so the next chip receives a value that is stable around its own rising edge. The whole register is presented in parallel for a downstream latch. The serial path is a plain shift chain with no valid/ready handshake and no back-pressure: every rising edge of the selected clock shifts exactly one bit, and the sender controls the pace by gating that clock.

Top module: `seg_shift_chain`

## Requirements
- R1: The register is `2*NPAIR` bits wide and appears on `seg_bits`. Bit `2*(n-1)+(k-1)` holds segment n, phase k (n = 1..NPAIR, k = 1..2), so bit 0 is segment 1 phase 1 and the top bit is segment NPAIR phase 2.
- R2: The register shifts on the rising edge of the selected shift clock: `clk_in_a` when `dir_up`=1, `clk_in_b` when `dir_up`=0. Edges on the other clock pin have no effect.
- R3: With `dir_up`=1, bits enter from `sdat_a` at bit 0 and move toward the top bit. After 2*NPAIR shifts, the j-th bit sent (j from 0) sits at bit 2*NPAIR-1-j.
- R4: With `dir_up`=0, bits enter from `sdat_b` at the top bit and move toward bit 0. After 2*NPAIR shifts, the j-th bit sent sits at bit j.
- R5: The far-end bit (the top bit when `dir_up`=1, bit 0 when `dir_up`=0) is captured on the falling edge of the selected shift clock and drives `sout_a`. The serial output does not change at a rising edge.
- R6: `sout_a` and `sout_b` carry the same value at all times, for either strap setting.
- R7: With `dir_up`=1, `clk_out_b` copies `clk_in_a` with `clk_out_b_en`=1, and `clk_out_a`=0 with `clk_out_a_en`=0. With `dir_up`=0 the two sides swap: `clk_out_a` copies `clk_in_b` with `clk_out_a_en`=1.
- R8: `rst` high clears the register and the serial output flop to zero at once, without waiting for a clock edge.
- R9: The data pin on the inactive side (`sdat_b` when `dir_up`=1, `sdat_a` when `dir_up`=0) has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Asynchronous active-high reset |
| dir_up | input | 1 | Static direction strap; may change only while rst is high |
| clk_in_a | input | 1 | Side-A shift clock input |
| clk_in_b | input | 1 | Side-B shift clock input |
| sdat_a | input | 1 | Side-A serial data input |
| sdat_b | input | 1 | Side-B serial data input |
| clk_out_a | output | 1 | Side-A forwarded clock |
| clk_out_a_en | output | 1 | Side-A clock pin acts as output |
| clk_out_b | output | 1 | Side-B forwarded clock |
| clk_out_b_en | output | 1 | Side-B clock pin acts as output |
| seg_bits | output | 2*NPAIR | Parallel register contents |
| sout_a | output | 1 | Retimed serial output |
| sout_b | output | 1 | Copy of sout_a |

## Verification
A parallel shift result is due at the same rising edge that takes the last bit, so the bench reads `seg_bits` 2 ns after that edge. The serial output is due half a period later: the bench reads it 1 ns after the next falling edge, and it also confirms that 2 ns after the rising edge the output still holds the far-end bit taken one falling edge before. The forwarded clock is combinational and is read in both clock phases. Reset clearing is read 1 ns after `rst` rises, with no clock edge in between.

// File: rtl/seg_shift_pkg.sv
package seg_shift_pkg;
  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } shift_dir_e;

  function automatic shift_dir_e to_dir(input logic strap);
    return strap ? DIR_UP : DIR_DOWN;
  endfunction
endpackage

// File: rtl/seg_shift_pin_route.sv
module seg_shift_pin_route
  import seg_shift_pkg::*;
(
  input  shift_dir_e dir,
  input  logic       clk_in_a,
  input  logic       clk_in_b,
  input  logic       sdat_a,
  input  logic       sdat_b,
  output logic       sclk,
  output logic       sdin,
  output logic       clk_out_a,
  output logic       clk_out_a_en,
  output logic       clk_out_b,
  output logic       clk_out_b_en
);
  always_comb begin
    if (dir == DIR_UP) begin
      sclk         = clk_in_a;
      sdin         = sdat_a;
      clk_out_a    = 1'b0;
      clk_out_a_en = 1'b0;
      clk_out_b    = clk_in_a;
      clk_out_b_en = 1'b1;
    end else begin
      sclk         = clk_in_b;
      sdin         = sdat_b;
      clk_out_a    = clk_in_b;
      clk_out_a_en = 1'b1;
      clk_out_b    = 1'b0;
      clk_out_b_en = 1'b0;
    end
  end
endmodule

// File: rtl/seg_shift_core.sv
module seg_shift_core
  import seg_shift_pkg::*;
#(
  parameter int WIDTH = 280
) (
  input  logic             sclk,
  input  logic             rst,
  input  shift_dir_e       dir,
  input  logic             sdin,
  output logic [WIDTH-1:0] q
);
  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] nxt;

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    logic from_low;
    logic from_high;
    if (i == 0) begin : g_lo_edge
      assign from_low = sdin;
    end else begin : g_lo_mid
      assign from_low = q[i-1];
    end
    if (i == TOP) begin : g_hi_edge
      assign from_high = sdin;
    end else begin : g_hi_mid
      assign from_high = q[i+1];
    end
    assign nxt[i] = (dir == DIR_UP) ? from_low : from_high;
  end

  always_ff @(posedge sclk or posedge rst) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end
endmodule

// File: rtl/seg_shift_retime.sv
module seg_shift_retime
  import seg_shift_pkg::*;
#(
  parameter int WIDTH = 280
) (
  input  logic             sclk,
  input  logic             rst,
  input  shift_dir_e       dir,
  input  logic [WIDTH-1:0] q,
  output logic             sout
);
  logic far_bit;

  assign far_bit = (dir == DIR_UP) ? q[WIDTH-1] : q[0];

  always_ff @(negedge sclk or posedge rst) begin
    if (rst) sout <= 1'b0;
    else     sout <= far_bit;
  end
endmodule

// File: rtl/seg_shift_chain.sv
module seg_shift_chain
  import seg_shift_pkg::*;
#(
  parameter int NPAIR = 140
) (
  input  logic               rst,
  input  logic               dir_up,
  input  logic               clk_in_a,
  input  logic               clk_in_b,
  input  logic               sdat_a,
  input  logic               sdat_b,
  output logic               clk_out_a,
  output logic               clk_out_a_en,
  output logic               clk_out_b,
  output logic               clk_out_b_en,
  output logic [2*NPAIR-1:0] seg_bits,
  output logic               sout_a,
  output logic               sout_b
);
  localparam int WIDTH = 2 * NPAIR;

  shift_dir_e dir;
  logic       sclk;
  logic       sdin;
  logic       sout;

  assign dir = to_dir(dir_up);

  seg_shift_pin_route u_route (
    .dir          (dir),
    .clk_in_a     (clk_in_a),
    .clk_in_b     (clk_in_b),
    .sdat_a       (sdat_a),
    .sdat_b       (sdat_b),
    .sclk         (sclk),
    .sdin         (sdin),
    .clk_out_a    (clk_out_a),
    .clk_out_a_en (clk_out_a_en),
    .clk_out_b    (clk_out_b),
    .clk_out_b_en (clk_out_b_en)
  );

  seg_shift_core #(.WIDTH(WIDTH)) u_core (
    .sclk (sclk),
    .rst  (rst),
    .dir  (dir),
    .sdin (sdin),
    .q    (seg_bits)
  );

  seg_shift_retime #(.WIDTH(WIDTH)) u_retime (
    .sclk (sclk),
    .rst  (rst),
    .dir  (dir),
    .q    (seg_bits),
    .sout (sout)
  );

  assign sout_a = sout;
  assign sout_b = sout;
endmodule

// File: rtl/seg_shift_chain_chk.sv
module seg_shift_chain_chk #(
  parameter int NPAIR = 140
) (
  input logic               rst,
  input logic               dir_up,
  input logic               clk_in_a,
  input logic               clk_in_b,
  input logic               sdat_a,
  input logic               sdat_b,
  input logic [2*NPAIR-1:0] seg_bits,
  input logic               sout_a,
  input logic               sout_b
);
  localparam int W = 2 * NPAIR;

  logic ck;
  logic far;
  assign ck  = dir_up ? clk_in_a : clk_in_b;
  assign far = dir_up ? seg_bits[W-1] : seg_bits[0];

  // R3: upward shift from side A
  p_shift_up_r3: assert property (@(posedge ck) disable iff (rst)
    (dir_up && !$past(rst)) |->
      (seg_bits[W-1:1] == $past(seg_bits[W-2:0]) && seg_bits[0] == $past(sdat_a)));

  // R4: downward shift from side B
  p_shift_down_r4: assert property (@(posedge ck) disable iff (rst)
    (!dir_up && !$past(rst)) |->
      (seg_bits[W-2:0] == $past(seg_bits[W-1:1]) && seg_bits[W-1] == $past(sdat_b)));

  // R5: serial output carries the far bit from the previous falling edge
  p_retime_r5: assert property (@(negedge ck) disable iff (rst)
    !$past(rst) |-> (sout_a == $past(far)));

  // R6: twin outputs agree
  p_twin_out_r6: assert property (@(posedge ck) disable iff (rst)
    sout_a == sout_b);

  // R8: held reset leaves everything clear
  p_reset_clear_r8: assert property (@(posedge ck)
    (rst && $past(rst)) |-> (seg_bits == '0 && sout_a == 1'b0));
endmodule

bind seg_shift_chain seg_shift_chain_chk #(.NPAIR(NPAIR)) u_chk (
  .rst      (rst),
  .dir_up   (dir_up),
  .clk_in_a (clk_in_a),
  .clk_in_b (clk_in_b),
  .sdat_a   (sdat_a),
  .sdat_b   (sdat_b),
  .seg_bits (seg_bits),
  .sout_a   (sout_a),
  .sout_b   (sout_b)
);

// File: tb/sim_seg_shift_chain.sv
`timescale 1ns/1ps
module sim_seg_shift_chain;
  localparam int NPAIR = 4;
  localparam int W     = 2 * NPAIR;

  logic clk = 1'b0;
  logic rst;
  logic dir_up;
  logic d_act;
  logic d_junk;
  logic clk_in_a, clk_in_b, sdat_a, sdat_b;
  logic clk_out_a, clk_out_a_en, clk_out_b, clk_out_b_en;
  logic [W-1:0] seg_bits;
  logic sout_a, sout_b;
  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  // active side gets the clock, inactive side gets its inverse
  assign clk_in_a = dir_up ? clk : ~clk;
  assign clk_in_b = dir_up ? ~clk : clk;
  assign sdat_a   = dir_up ? d_act : d_junk;
  assign sdat_b   = dir_up ? d_junk : d_act;

  seg_shift_chain #(.NPAIR(NPAIR)) u0 (
    .rst(rst), .dir_up(dir_up), .clk_in_a(clk_in_a), .clk_in_b(clk_in_b),
    .sdat_a(sdat_a), .sdat_b(sdat_b), .clk_out_a(clk_out_a),
    .clk_out_a_en(clk_out_a_en), .clk_out_b(clk_out_b),
    .clk_out_b_en(clk_out_b_en), .seg_bits(seg_bits),
    .sout_a(sout_a), .sout_b(sout_b)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] rev(input logic [W-1:0] v);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = v[W-1-i];
    return r;
  endfunction

  task automatic check_clk_out(input logic level);
    if (dir_up) begin
      check("R7 b out", {7'd0, clk_out_b}, {7'd0, level});
      check("R7 ens", {6'd0, clk_out_a_en, clk_out_b_en}, 8'd1);
      check("R7 a idle", {7'd0, clk_out_a}, 8'd0);
    end else begin
      check("R7 a out", {7'd0, clk_out_a}, {7'd0, level});
      check("R7 ens", {6'd0, clk_out_a_en, clk_out_b_en}, 8'd2);
      check("R7 b idle", {7'd0, clk_out_b}, 8'd0);
    end
  endtask

  task automatic sweep(input logic up);
    logic [W-1:0] prev;
    @(negedge clk);
    rst    = 1'b1;
    dir_up = up;
    repeat (3) @(negedge clk);
    #1;
    check("R8 reset bits", seg_bits, '0);
    check("R8 reset sout", {7'd0, sout_a}, 8'd0);
    rst  = 1'b0;
    prev = '0;
    for (int p = 0; p < (1 << W); p++) begin
      for (int j = 0; j < W; j++) begin
        if (j != 0) @(negedge clk);
        #1;
        if (j == 0 && p != 0) begin
          // R5: far bit (first bit sent) appears at the falling edge
          check("R5 sout after fall", {7'd0, sout_a}, {7'd0, prev[0]});
          check("R6 twin", {7'd0, sout_b}, {7'd0, sout_a});
          check_clk_out(1'b0);
        end
        d_act  = p[j];
        d_junk = $urandom_range(0, 1); // R9 stimulus on unused pin
        @(posedge clk);
        #2;
        if (j == W - 1) begin
          check(up ? "R3 R1 R2 R9 load" : "R4 R1 R2 R9 load", seg_bits,
                up ? rev(W'(p)) : W'(p));
          check("R5 no change at rise", {7'd0, sout_a}, {7'd0, prev[W-1]});
          if (p % 37 == 0) check_clk_out(1'b1);
        end
      end
      prev = W'(p);
      @(negedge clk);
    end
    #1;
    check("R5 final sout", {7'd0, sout_a}, {7'd0, prev[0]});
    // R8: reset clears at once without a clock edge
    @(posedge clk);
    #1;
    rst = 1'b1;
    #1;
    check("R8 async clear", seg_bits, '0);
    check("R8 async sout", {7'd0, sout_b}, 8'd0);
  endtask

  initial begin
    rst    = 1'b1;
    dir_up = 1'b1;
    d_act  = 1'b0;
    d_junk = 1'b0;
    sweep(1'b1);
    sweep(1'b0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        #1500000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule